// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block decides which analog input a successive-approximation converter samples next, and when. It serves eight logical inputs, numbered 0 to 7 and split into a low group (0–3) and a high group (4–7). A 2-bit mode input and a 3-bit channel field choose the channel list for a run:

- a single conversion of one channel;
- a scan of part of one group;
- a paired scan that takes the same number of leading channels from both groups.

For each channel in the run the block issues a one-cycle start strobe and presents the channel index. It then waits for the converter's done pulse before moving on. After the last channel it emits a one-cycle end-of-scan pulse.

A run can begin in three ways: a software start input, a falling edge on an external trigger pin, or a conversion request from an interval timer. An 8-bit trigger register selects which of the two hardware sources is used, and a separate enable input gates both hardware sources. The mode and channel inputs are captured only when a run begins.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `convStart` and `scanEnd` are 0, and `trgRdData` reads 0xFF.
- R2: Mode code 2'b00 (and the unused code 2'b11) performs one conversion of the channel given by `chanIn`.
- R3: Mode code 2'b01 scans `chanIn[1:0]`+1 channels in ascending order. They come from the low group when `chanIn[2]`=0 and from the high group (channel numbers 4 and up) when `chanIn[2]`=1, starting at the group's lowest channel.
- R4: Mode code 2'b10 takes N=`chanIn[1:0]`+1 and converts low channels 0..N-1, then high channels 4..3+N, in that order. `chanIn[2]` has no effect.
- R5: Each conversion in a run is announced by a `convStart` pulse exactly one cycle wide. `convChan` holds its value until the next start, and the next start comes only after a `convDone` pulse.
- R6: `scanEnd` is high for exactly one cycle, in the cycle after the `convDone` that completes the last channel. `busy` is 0 from that cycle on.
- R7: Only bit 7 of the trigger register can be written. Bits 6:0 always read as 1, whatever value is written to them.
- R8: Trigger register bit 7 = 1 selects the external pin, which starts a run on a falling edge after a two-flop synchroniser; a rising edge does nothing. Bit 7 = 0 selects the timer request pulse, and the pin is then ignored.
- R9: While `trigEn` is 0, neither hardware source starts a run, but `swStart` still does.
- R10: A software start or hardware trigger that arrives while a run is in progress is discarded. It does not start another run afterwards.
- R11: Changes to `modeIn` or `chanIn` during a run do not alter that run's channel list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeIn | input | 2 | Scan mode code (00 single, 01 group scan, 10 paired scan) |
| chanIn | input | 3 | Channel field |
| trgWrEn | input | 1 | Trigger register write strobe |
| trgWrData | input | 8 | Trigger register write data |
| trgRdData | output | 8 | Trigger register read value |
| trigEn | input | 1 | Hardware trigger enable |
| swStart | input | 1 | Software start pulse |
| extTrigPin | input | 1 | Asynchronous external trigger pin |
| timerReq | input | 1 | Interval-timer conversion request pulse |
| convStart | output | 1 | Start-conversion strobe |
| convChan | output | 3 | Channel index for the converter |
| convDone | input | 1 | Converter done pulse |
| scanEnd | output | 1 | End-of-scan pulse |
| busy | output | 1 | Run in progress |

## Verification
The bench runs every mode code against every channel field value. It compares each observed channel list with one derived arithmetically, which catches a paired scan that honours bit 2, a group offset that is misplaced, or a length that is off by one. Some runs change the mode and field and fire extra starts partway through. A design that reads its configuration live, or that queues a trigger, then converts the wrong channels or starts a phantom run. The trigger paths are tried with each source selection and with the enable both high and low, and with both pin polarities, to expose a source that is wired backwards, a gate that is missing, or an edge detector on the wrong edge.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_GROUP  = 2'b01,
    MODE_PAIRED = 2'b10,
    MODE_SPARE  = 2'b11
  } scanMode_e;

  typedef struct packed {
    logic loadCfg;
    logic advance;
    logic busy;
  } ctlStrb_t;
endpackage

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrb_t                   strb,
  input  logic [1:0]                 modeIn,
  input  logic [$clog2(NUM_CH)-1:0]  chanIn,
  input  logic                       trgWrEn,
  input  logic [7:0]                 trgWrData,
  output logic [7:0]                 trgRdData,
  input  logic                       trigEn,
  input  logic                       swStart,
  input  logic                       extTrigPin,
  input  logic                       timerReq,
  output logic                       startReq,
  output logic                       lastCh,
  output logic [$clog2(NUM_CH)-1:0]  chanOut
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int GRP   = NUM_CH / 2;
  localparam int GRP_W = CH_W - 1;
  localparam int CNT_W = CH_W + 1;

  // trigger source register: only the top bit is stored
  logic trgSrcExt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        trgSrcExt <= 1'b1;
    else if (trgWrEn) trgSrcExt <= trgWrData[7];
  end
  assign trgRdData = {trgSrcExt, 7'h7F};

  // external pin synchroniser and falling-edge detector
  logic [2:0] pinSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinSync <= '1;
    else       pinSync <= {pinSync[1:0], extTrigPin};
  end
  logic extFall;
  assign extFall = pinSync[2] & ~pinSync[1];

  logic hwTrig;
  assign hwTrig   = trigEn & (trgSrcExt ? extFall : timerReq);
  assign startReq = swStart | hwTrig;

  // configuration captured at run start
  scanMode_e         latMode;
  logic [CH_W-1:0]   latField;
  logic [CNT_W-1:0]  idx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latMode  <= MODE_SINGLE;
      latField <= '0;
      idx      <= '0;
    end else if (strb.loadCfg) begin
      latMode  <= scanMode_e'(modeIn);
      latField <= chanIn;
      idx      <= '0;
    end else if (strb.advance) begin
      idx <= idx + 1'b1;
    end
  end

  logic [CNT_W-1:0] grpLen;
  logic [CNT_W-1:0] runLen;
  assign grpLen = CNT_W'(latField[GRP_W-1:0]) + 1'b1;

  always_comb begin
    unique case (latMode)
      MODE_GROUP:  runLen = grpLen;
      MODE_PAIRED: runLen = grpLen << 1;
      default:     runLen = CNT_W'(1);
    endcase
  end
  assign lastCh = (idx == runLen - 1'b1);

  always_comb begin
    unique case (latMode)
      MODE_GROUP:  chanOut = {latField[CH_W-1], idx[GRP_W-1:0]};
      MODE_PAIRED: chanOut = (idx < grpLen) ? idx[CH_W-1:0]
                                            : CH_W'(idx - grpLen + CNT_W'(GRP));
      default:     chanOut = latField;
    endcase
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.loadCfg) |=> ($stable(latMode) && $stable(latField))); // R11
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadCfg && !strb.advance) |=> $stable(chanOut)); // R5
  AST_TRG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    trgWrEn |=> (trgRdData[7] == $past(trgWrData[7]))); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |-> (idx < CNT_W'(NUM_CH))); // R4
endmodule

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl
  import adc_scan_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     lastCh,
  input  logic     convDone,
  output ctlStrb_t strb,
  output logic     convStart,
  output logic     scanEnd
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;
  state_e state, stateNxt;
  logic   endQ, endNxt;

  always_comb begin
    stateNxt     = state;
    endNxt       = 1'b0;
    strb.loadCfg = 1'b0;
    strb.advance = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        strb.loadCfg = 1'b1;
        stateNxt     = ST_ISSUE;
      end
      ST_ISSUE: stateNxt = ST_WAIT;
      ST_WAIT: if (convDone) begin
        if (lastCh) begin
          endNxt   = 1'b1;
          stateNxt = ST_IDLE;
        end else begin
          strb.advance = 1'b1;
          stateNxt     = ST_ISSUE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
  assign strb.busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      endQ  <= 1'b0;
    end else begin
      state <= stateNxt;
      endQ  <= endNxt;
    end
  end

  assign convStart = (state == ST_ISSUE);
  assign scanEnd   = endQ;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R5
  AST_END_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    scanEnd |-> $past(convDone)); // R6
  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    scanEnd |=> !scanEnd); // R6
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    scanEnd |-> !strb.busy); // R6
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [1:0]                modeIn,
  input  logic [$clog2(NUM_CH)-1:0] chanIn,
  input  logic                      trgWrEn,
  input  logic [7:0]                trgWrData,
  output logic [7:0]                trgRdData,
  input  logic                      trigEn,
  input  logic                      swStart,
  input  logic                      extTrigPin,
  input  logic                      timerReq,
  output logic                      convStart,
  output logic [$clog2(NUM_CH)-1:0] convChan,
  input  logic                      convDone,
  output logic                      scanEnd,
  output logic                      busy
);
  ctlStrb_t strb;
  logic     startReq;
  logic     lastCh;

  adc_scan_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .lastCh    (lastCh),
    .convDone  (convDone),
    .strb      (strb),
    .convStart (convStart),
    .scanEnd   (scanEnd)
  );

  adc_scan_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .modeIn     (modeIn),
    .chanIn     (chanIn),
    .trgWrEn    (trgWrEn),
    .trgWrData  (trgWrData),
    .trgRdData  (trgRdData),
    .trigEn     (trigEn),
    .swStart    (swStart),
    .extTrigPin (extTrigPin),
    .timerReq   (timerReq),
    .startReq   (startReq),
    .lastCh     (lastCh),
    .chanOut    (convChan)
  );

  assign busy = strb.busy;
endmodule

// File: tb/adc_scan_ctrl_tb.sv
`timescale 1ns/1ps
module adc_scan_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeIn = 2'b00;
  logic [2:0] chanIn = 3'd0;
  logic       trgWrEn = 1'b0;
  logic [7:0] trgWrData = 8'h00;
  logic [7:0] trgRdData;
  logic       trigEn = 1'b0;
  logic       swStart = 1'b0;
  logic       extTrigPin = 1'b1;
  logic       timerReq = 1'b0;
  logic       convStart;
  logic [2:0] convChan;
  logic       convDone = 1'b0;
  logic       scanEnd;
  logic       busy;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  adc_scan_ctrl u_dut (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .chanIn(chanIn),
    .trgWrEn(trgWrEn), .trgWrData(trgWrData), .trgRdData(trgRdData),
    .trigEn(trigEn), .swStart(swStart), .extTrigPin(extTrigPin),
    .timerReq(timerReq), .convStart(convStart), .convChan(convChan),
    .convDone(convDone), .scanEnd(scanEnd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expLen(input int m, input int f);
    if (m == 1) return (f % 4) + 1;
    if (m == 2) return 2 * ((f % 4) + 1);
    return 1;
  endfunction

  function automatic int expChan(input int m, input int f, input int i);
    int n = (f % 4) + 1;
    if (m == 1) return (f / 4) * 4 + i;
    if (m == 2) return (i < n) ? i : 4 + (i - n);
    return f;
  endfunction

  task automatic writeTrg(input logic [7:0] d);
    trgWrData = d; trgWrEn = 1'b1;
    @(negedge clk);
    trgWrEn = 1'b0;
  endtask

  task automatic expectQuiet(input int cycles, input string req);
    bit seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (convStart || busy) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  // runs a scan that has just been triggered; polls for the first start
  task automatic runScan(input int m, input int f, input bit scramble, input string req);
    int got[16];
    int n = 0;
    int w = 0;
    bit done = 0;
    while (!convStart && w < 12) begin @(negedge clk); w++; end
    if (!convStart) begin
      check(0, req, 0, 1);
      return;
    end
    while (!done && n < 16) begin
      got[n] = convChan;
      n++;
      if (scramble && n == 1) begin
        modeIn = ~modeIn; chanIn = ~chanIn; swStart = 1'b1; timerReq = 1'b1;
      end
      @(negedge clk);
      swStart = 1'b0; timerReq = 1'b0;
      check(!convStart && convChan == got[n-1], "R5", convStart, 0);
      @(negedge clk);
      check(!convStart && !scanEnd, "R5", convStart, 0);
      convDone = 1'b1;
      @(negedge clk);
      convDone = 1'b0;
      if (scanEnd) done = 1;
      else if (!convStart) begin
        check(0, "R5", 0, 1);
        done = 1;
      end
    end
    check(n == expLen(m, f), req, n, expLen(m, f));
    for (int i = 0; i < n && i < expLen(m, f); i++)
      check(got[i] == expChan(m, f, i), req, got[i], expChan(m, f, i));
    check(!busy, "R6", busy, 0);
    @(negedge clk);
    check(!scanEnd && !busy, "R6", scanEnd, 0);
    modeIn = 2'(m); chanIn = 3'(f);
    if (scramble) expectQuiet(6, "R10");
  endtask

  task automatic swScan(input int m, input int f, input bit scramble, input string req);
    modeIn = 2'(m); chanIn = 3'(f);
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
    runScan(m, f, scramble, req);
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !convStart && !scanEnd, "R1", busy, 0);
    check(trgRdData == 8'hFF, "R1", trgRdData, 8'hFF);
    rstN = 1'b1;
    @(negedge clk);
    check(trgRdData == 8'hFF && !busy, "R1", trgRdData, 8'hFF);

    // R7: reserved bits
    writeTrg(8'h00); check(trgRdData == 8'h7F, "R7", trgRdData, 8'h7F);
    writeTrg(8'h80); check(trgRdData == 8'hFF, "R7", trgRdData, 8'hFF);
    writeTrg(8'h7F); check(trgRdData == 8'h7F, "R7", trgRdData, 8'h7F);
    writeTrg(8'h80);

    // exhaustive sweep of mode codes and field values
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 8; f++)
        swScan(m, f, 1'b0, (m == 1) ? "R3" : (m == 2) ? "R4" : "R2");

    // R11/R10: config changes and extra starts mid-run
    swScan(1, 5, 1'b1, "R11");
    swScan(2, 3, 1'b1, "R11");
    swScan(0, 6, 1'b1, "R11");

    // R9: hardware triggers gated off
    trigEn = 1'b0;
    modeIn = 2'b00; chanIn = 3'd2;
    extTrigPin = 1'b0; expectQuiet(8, "R9");
    extTrigPin = 1'b1; expectQuiet(4, "R9");
    writeTrg(8'h00);
    timerReq = 1'b1; @(negedge clk); timerReq = 1'b0;
    expectQuiet(6, "R9");
    swScan(0, 2, 1'b0, "R9");

    // R8: source selection
    trigEn = 1'b1;
    extTrigPin = 1'b0; expectQuiet(8, "R8");
    extTrigPin = 1'b1; expectQuiet(4, "R8");
    modeIn = 2'b01; chanIn = 3'd6;
    timerReq = 1'b1; @(negedge clk); timerReq = 1'b0;
    runScan(1, 6, 1'b0, "R8");
    writeTrg(8'hFF);
    timerReq = 1'b1; @(negedge clk); timerReq = 1'b0;
    expectQuiet(6, "R8");
    modeIn = 2'b10; chanIn = 3'd1;
    extTrigPin = 1'b0; @(negedge clk);
    runScan(2, 1, 1'b0, "R8");
    extTrigPin = 1'b1; expectQuiet(8, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule